// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Bus Link

This block joins a bus master and a bus slave that run on unrelated clocks. A single transfer, either a read or a write, is sequenced only by the edges of a request line and an acknowledge line. Each side passes the other side's handshake line through a two-flop synchronizer before using it. The master presents the address and the direction from the moment it accepts a command. On a write it also presents the data. It then waits a programmable number of its own cycles before raising the request, so the slave can decode the target.

The slave holds a small register file. On a write it stores the bus data and raises the acknowledge. On a read it places the addressed register on the bus and raises the acknowledge in the same cycle. The master drops the request once it sees the acknowledge, and on a read it captures the bus data in that same cycle. The slave drops the acknowledge once it sees the request low. The master reports completion only after it sees the acknowledge low, so the link never carries two transfers at once. Local logic uses the master's command port: a start strobe, a direction, an address and write data in, and busy, a done pulse and read data out.

Top module: `hs_link`

## Requirements
- R1: While rst_ni is low, and after it is released, bus_req_o, bus_ack_o, bus_drive_o, busy_o and done_o are 0, rdata_o is 0, and every slave register reads back 0.
- R2: A write of value V to address A (wr_i=1) followed by a read of A (wr_i=0) returns V on rdata_o, and writes to other addresses do not change it.
- R3: bus_req_o rises exactly DECODE_CYC master clock edges after the edge that accepts start_i, with DECODE_CYC defaulting to 2.
- R4: The master drops the request only after its synchronized copy of the acknowledge is high. On a read it captures the bus data at that point.
- R5: The master holds the address, direction and write data constant from acceptance until it sees the acknowledge low. It then pulses done_o high for exactly one master cycle, and busy_o falls at the same edge.
- R6: The slave raises the acknowledge only after it has seen the request high, and drops it only after it has seen the request low.
- R7: The slave drives the data lines (bus_drive_o=1) only during a read, and only while its acknowledge is high. It never drives them during a write.
- R8: start_i is ignored while busy_o is high. A second command issued mid-transfer changes neither the transfer in flight nor any register.
- R9: rdata_o keeps the value of the last completed read until the next read completes. Writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m_i | input | 1 | Master-side clock |
| clk_s_i | input | 1 | Slave-side clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both sides |
| start_i | input | 1 | Command strobe, accepted when idle |
| wr_i | input | 1 | Direction: 1 write, 0 read |
| addr_i | input | AW | Register address |
| wdata_i | input | DW | Write data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Data of the last completed read |
| bus_req_o | output | 1 | Request line as driven by the master |
| bus_ack_o | output | 1 | Acknowledge line as driven by the slave |
| bus_drive_o | output | 1 | Slave data-line output enable |

## Verification
A corrupted register in the slave shows up on rdata_o at the done pulse of the next read to that address, within one transfer of about twenty master cycles. A master that skips or miscounts the decode wait moves the rise of bus_req_o by at least one master cycle from its expected edge, and this is visible on the first transfer. A broken interlock shows up at the ports within a few cycles. It appears as an acknowledge that rises before any request, a request that falls before any acknowledge, a done pulse that arrives early or lasts too long, or bus_drive_o asserted during a write.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_SETUP = 2'd1,
    M_REQ   = 2'd2,
    M_REL   = 2'd3
  } m_state_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_HOLD = 1'b1
  } s_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/hs_master.sv
module hs_master
  import hs_pkg::*;
#(
  parameter int AW         = 2,
  parameter int DW         = 8,
  parameter int DECODE_CYC = 2,
  parameter int SYNC_STG   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  input  logic          ack_i,
  output logic          req_o,
  output logic          bus_wr_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic          bus_oe_o,
  input  logic [DW-1:0] bus_rdata_i
);
  localparam int CW = (DECODE_CYC > 1) ? $clog2(DECODE_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DECODE_CYC - 1);

  m_state_e      state_q;
  logic [CW-1:0] cnt_q;
  logic          req_q, done_q, wr_q, ack_s;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  hs_sync #(.STAGES(SYNC_STG)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_i),
    .q_o   (ack_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= M_IDLE;
      cnt_q   <= '0;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        M_IDLE: begin
          if (start_i) begin
            wr_q    <= wr_i;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            cnt_q   <= '0;
            state_q <= M_SETUP;
          end
        end
        M_SETUP: begin
          // decode interval before request
          if (cnt_q == CNT_LAST) begin
            req_q   <= 1'b1;
            state_q <= M_REQ;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        M_REQ: begin
          if (ack_s) begin
            req_q <= 1'b0;
            if (!wr_q) rdata_q <= bus_rdata_i;
            state_q <= M_REL;
          end
        end
        M_REL: begin
          if (!ack_s) begin
            done_q  <= 1'b1;
            state_q <= M_IDLE;
          end
        end
        default: state_q <= M_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != M_IDLE);
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign req_o       = req_q;
  assign bus_wr_o    = wr_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign bus_oe_o    = wr_q && (state_q != M_IDLE);

  // R4: request released only after synchronized ack seen
  a_r4_req_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_q) |-> $past(ack_s));

  // R5: bus fields frozen while a transfer is open
  a_r5_hold_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != M_IDLE && $past(state_q != M_IDLE)) |->
      ($stable(addr_q) && $stable(wr_q) && $stable(wdata_q)));

  // R5: done is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R5: done only after ack seen low
  a_r5_done_ack_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> !$past(ack_s));

  // R3: request never raised from idle
  a_r3_req_from_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(state_q == M_SETUP));
endmodule

// File: rtl/hs_slave.sv
module hs_slave
  import hs_pkg::*;
#(
  parameter int AW       = 2,
  parameter int DW       = 8,
  parameter int SYNC_STG = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic          oe_o
);
  localparam int NREG = 1 << AW;

  s_state_e      state_q;
  logic          ack_q, oe_q, req_s;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] regs_q [NREG];

  hs_sync #(.STAGES(SYNC_STG)) u_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
      rdata_q <= '0;
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (req_s) begin
            if (wr_i) begin
              regs_q[addr_i] <= wdata_i;
            end else begin
              rdata_q <= regs_q[addr_i];
              oe_q    <= 1'b1;
            end
            ack_q   <= 1'b1;
            state_q <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (!req_s) begin
            ack_q   <= 1'b0;
            oe_q    <= 1'b0;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ack_o   = ack_q;
  assign oe_o    = oe_q;
  assign rdata_o = rdata_q;

  // R6: ack rises only on seen request
  a_r6_ack_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> $past(req_s));

  // R6: ack falls only on seen release
  a_r6_ack_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_q) |-> !$past(req_s));

  // R7: data lines driven only on read with ack high
  a_r7_drive_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> (ack_q && !wr_i));
endmodule

// File: rtl/hs_link.sv
module hs_link #(
  parameter int AW         = 2,
  parameter int DW         = 8,
  parameter int DECODE_CYC = 2,
  parameter int SYNC_STG   = 2
) (
  input  logic          clk_m_i,
  input  logic          clk_s_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          bus_req_o,
  output logic          bus_ack_o,
  output logic          bus_drive_o
);
  logic          req, ack, m_wr, m_oe, s_oe;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata, s_rdata, bus_data;

  hs_master #(
    .AW(AW), .DW(DW), .DECODE_CYC(DECODE_CYC), .SYNC_STG(SYNC_STG)
  ) u_master (
    .clk_i      (clk_m_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rdata_o    (rdata_o),
    .ack_i      (ack),
    .req_o      (req),
    .bus_wr_o   (m_wr),
    .bus_addr_o (m_addr),
    .bus_wdata_o(m_wdata),
    .bus_oe_o   (m_oe),
    .bus_rdata_i(bus_data)
  );

  hs_slave #(
    .AW(AW), .DW(DW), .SYNC_STG(SYNC_STG)
  ) u_slave (
    .clk_i  (clk_s_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .wr_i   (m_wr),
    .addr_i (m_addr),
    .wdata_i(bus_data),
    .ack_o  (ack),
    .rdata_o(s_rdata),
    .oe_o   (s_oe)
  );

  // shared data lines modeled as enable-selected mux
  assign bus_data    = m_oe ? m_wdata : (s_oe ? s_rdata : '0);
  assign bus_req_o   = req;
  assign bus_ack_o   = ack;
  assign bus_drive_o = s_oe;
endmodule

// File: tb/sim_hs_link.sv
module sim_hs_link;
  localparam int CLK_PERIOD  = 10;
  localparam int SCLK_PERIOD = 14;
  localparam int AW = 2;
  localparam int DW = 8;
  localparam int DEC = 2;
  localparam int NREG = 1 << AW;

  logic clk_m = 1'b0, clk_s = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic busy, done, req, ack, drive;
  logic [DW-1:0] rdata;

  int checks = 0, errors = 0;
  logic [DW-1:0] model [NREG];
  logic [DW-1:0] last_rd = '0;
  logic cur_wr = 1'b0;
  int viol_ack = 0, viol_drive = 0;
  logic prev_req = 1'b0, prev_ack = 1'b0;

  always #(CLK_PERIOD/2)  clk_m = ~clk_m;
  always #(SCLK_PERIOD/2) clk_s = ~clk_s;

  hs_link #(.AW(AW), .DW(DW), .DECODE_CYC(DEC)) u0 (
    .clk_m_i(clk_m), .clk_s_i(clk_s), .rst_ni(rst_n),
    .start_i(start), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .bus_req_o(req), .bus_ack_o(ack), .bus_drive_o(drive)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // slave-side protocol monitor (R6, R7)
  always @(negedge clk_s) begin
    if (rst_n) begin
      if (ack && !prev_ack && !prev_req) viol_ack++;
      if (!ack && prev_ack && prev_req)  viol_ack++;
      if (drive && (cur_wr || !ack))     viol_drive++;
    end
    prev_req = req;
    prev_ack = ack;
  end

  task automatic xfer(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit inject, input logic [AW-1:0] ia, input logic [DW-1:0] id);
    int n;
    @(negedge clk_m);
    cur_wr = w;
    start = 1'b1; wr = w; addr = a; wdata = d;
    n = 0;
    forever begin
      @(negedge clk_m);
      start = 1'b0;
      n++;
      if (inject && n == 1) begin
        start = 1'b1; wr = 1'b1; addr = ia; wdata = id;   // R8 mid-transfer command
      end
      if (req || n > 200) break;
    end
    start = 1'b0;
    check(n == DEC + 1, "R3 decode wait", n, DEC + 1);
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk_m);
      n++;
      if (!done) begin
        check(1'b1, "R5 hold", 0, 0);
        checks--;
      end
    end
    check(done == 1'b1, "R5 done seen", done, 1);
    check(ack == 1'b0 && req == 1'b0, "R5 lines low at done", {req, ack}, 0);
    check(busy == 1'b0, "R5 busy low at done", busy, 0);
    if (w) begin
      model[a] = d;
      check(rdata == last_rd, "R9 rdata kept across write", rdata, last_rd);
    end else begin
      check(rdata == model[a], "R2 R4 read data", rdata, model[a]);
      last_rd = model[a];
    end
    @(negedge clk_m);
    check(done == 1'b0, "R5 done one cycle", done, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = '0;
    #(CLK_PERIOD * 3 + 1);
    check(!req && !ack && !drive && !busy && !done, "R1 reset lines", {req, ack, drive, busy, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_m);
    check(!req && !ack && !drive && !busy && !done, "R1 after release", {req, ack, drive, busy, done}, 0);
    check(rdata == '0, "R1 rdata", rdata, 0);
    // R1: every register reads zero
    for (int a = 0; a < NREG; a++) xfer(1'b0, AW'(a), '0, 1'b0, '0, '0);

    // R2 sweep: patterns per pass, writes then reads
    for (int p = 0; p < 3; p++) begin
      for (int a = 0; a < NREG; a++)
        xfer(1'b1, AW'(a), DW'((a * 53 + p * 29 + 7) ^ (p * 85)), 1'b0, '0, '0);
      for (int a = NREG - 1; a >= 0; a--) xfer(1'b0, AW'(a), '0, 1'b0, '0, '0);
    end

    // R8: command during busy is ignored
    xfer(1'b1, 2'd1, 8'hA5, 1'b1, 2'd1, 8'h3C);
    xfer(1'b1, 2'd2, 8'h5A, 1'b1, 2'd3, 8'hC3);
    xfer(1'b0, 2'd1, '0, 1'b0, '0, '0);
    check(rdata == 8'hA5, "R8 ignored start addr1", rdata, 8'hA5);
    xfer(1'b0, 2'd3, '0, 1'b0, '0, '0);
    check(rdata == model[3], "R8 ignored start addr3", rdata, model[3]);
    xfer(1'b0, 2'd2, '0, 1'b0, '0, '0);
    check(rdata == 8'h5A, "R8 in-flight write kept", rdata, 8'h5A);

    // R9: write after read leaves rdata
    xfer(1'b1, 2'd0, 8'hFF, 1'b0, '0, '0);
    check(rdata == 8'h5A, "R9 rdata after write", rdata, 8'h5A);

    repeat (10) @(negedge clk_m);
    check(viol_ack == 0, "R6 ack interlock", viol_ack, 0);
    check(viol_drive == 0, "R7 drive window", viol_drive, 0);
    check(!drive && !busy, "R7 idle undriven", {drive, busy}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule